// File: doc/BRIEF.md
# Card Data Byte FIFO Mover

This block carries the data phase of a memory-card transfer between a processor and a byte-wide card data port. A start pulse loads a transfer length, which is the block count multiplied by the block length, and a direction bit. From then on the block moves one byte per accepted handshake and counts the remaining length down. When the count reaches zero, the transfer goes idle and sets the completion flags.

In the card-to-processor direction, bytes from the card land in a 32-byte circular receive FIFO. The processor drains it with read strobes that return one, two or four bytes packed into a 32-bit word. In the processor-to-card direction, write strobes deliver one, two or four bytes into a 32-byte transmit FIFO, and the block hands them to the card in arrival order. Both FIFOs raise a service request so a processor or DMA engine knows when to act.

The card side uses valid/ready streams. Receive: the card drives `card_rx_valid` with a byte and keeps it stable until `card_rx_ready` is high at a rising edge. The block withholds ready while its FIFO is full, while no bytes remain, while the transfer is idle, or while the direction is transmit. Transmit: the block presents the oldest pending byte with `card_tx_valid`. The card may hold `card_tx_ready` low for any number of cycles; the byte and valid stay put until the card takes it. At most one byte crosses per clock in either direction.

Top module: `card_byte_mover`

## Requirements
- R1: A `start` pulse loads `start_blocks * start_blklen` into `bytes_left` and latches `start_dir` (0 = card to processor, 1 = processor to card). It also empties both FIFOs and clears both requests and both done flags. `active` becomes 1 in the next cycle if the product is nonzero. If the product is zero, `active` stays 0 and `data_done` is set instead, and `prog_done` too when the direction is 1.
- R2: `card_rx_ready` is high exactly when `active` is 1, the direction is 0, `bytes_left` is nonzero, `rx_level` is below 32 and `abort` is low. Each accepted byte is appended to the receive FIFO, decrements `bytes_left`, and sets `rx_req` at that edge.
- R3: `acc_size` selects the access width: 0 means one byte, 1 means two bytes, and 2 or 3 mean four bytes. A `cpu_rd` strobe of n bytes takes k = min(n, `rx_level`) bytes. During the strobe, `cpu_rdata` carries the first byte taken in lane n-1 (bits 8n-1:8n-8), the following bytes in successively lower lanes, and zeros in every lane not filled. The strobe clears `rx_req` unless a card byte is accepted in the same cycle.
- R4: `card_tx_valid` is high exactly when `active` is 1, the direction is 1, `tx_level` is nonzero, and `abort` and `tx_release` are low. `card_tx_data` is the oldest pending byte. Each accepted byte removes it and decrements `bytes_left`.
- R5: A `cpu_wr` strobe of n bytes appends bytes from lane n-1 of `cpu_wdata` downward, stopping once 32 bytes are pending. The remaining bytes of that access are dropped. The strobe clears `tx_req`.
- R6: `tx_req` is set at any edge where `active` is 1, the direction is 1, `bytes_left` is nonzero, `tx_level` is 0 and `cpu_wr` is low.
- R7: The byte that brings `bytes_left` to zero drops `active` and sets `data_done`. In direction 1 it also sets `prog_done`; in direction 0, `prog_done` stays 0. Both flags hold until the next start.
- R8: A `tx_release` pulse discards all pending transmit bytes, so `tx_level` is 0 in the next cycle.
- R9: While `abort` is high, no card handshake is offered. `active` is 0 in the next cycle, `bytes_left` is held, and neither done flag is set.
- R10: Bytes leave each FIFO in arrival order across pointer wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer |
| start_dir | input | 1 | Direction: 0 card to processor, 1 processor to card |
| start_blocks | input | NBLK_W | Number of blocks |
| start_blklen | input | BLEN_W | Bytes per block |
| abort | input | 1 | Stop the current transfer (clock stop or new command) |
| tx_release | input | 1 | Discard pending transmit bytes |
| cpu_rd | input | 1 | Receive FIFO read strobe |
| cpu_wr | input | 1 | Transmit FIFO write strobe |
| acc_size | input | 2 | Access width code |
| cpu_wdata | input | 32 | Write data, first byte in the top lane of the width |
| cpu_rdata | output | 32 | Read data, valid during `cpu_rd` |
| card_rx_valid | input | 1 | Card byte available |
| card_rx_data | input | 8 | Card byte |
| card_rx_ready | output | 1 | Block accepts a card byte |
| card_tx_valid | output | 1 | Byte offered to the card |
| card_tx_data | output | 8 | Byte to the card |
| card_tx_ready | input | 1 | Card accepts the byte |
| rx_req | output | 1 | Receive FIFO service request |
| tx_req | output | 1 | Transmit FIFO service request |
| data_done | output | 1 | Transfer finished |
| prog_done | output | 1 | Write transfer finished |
| active | output | 1 | Transfer in progress |
| bytes_left | output | NBLK_W+BLEN_W | Remaining byte count |
| rx_level | output | $clog2(DEPTH)+1 | Receive FIFO fill |
| tx_level | output | $clog2(DEPTH)+1 | Transmit FIFO fill |

## Verification
A corrupted read or write pointer shows on the next strobe or handshake as a byte out of sequence, because every byte carries a position-dependent pattern. A wrong fill count shows in the same cycle as a level that disagrees with the bench's tally, or as a ready or valid offered when the FIFO is full or empty. A miscounted length shows at the end of a transfer as an early or missing done flag, or, with abort, as a held `bytes_left` that differs by even one byte. A stale request bit shows within one cycle, because the bench predicts both requests at every edge.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int CPU_BYTES = 4;

  typedef enum logic {
    DIR_TO_CPU  = 1'b0,
    DIR_TO_CARD = 1'b1
  } xfer_dir_e;

  // access width code to byte count
  function automatic logic [2:0] acc_bytes(input logic [1:0] code);
    case (code)
      2'd0:    acc_bytes = 3'd1;
      2'd1:    acc_bytes = 3'd2;
      default: acc_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/bm_byte_ring.sv
module bm_byte_ring #(
  parameter int DEPTH    = 32,
  parameter int PUSH_MAX = 1,
  parameter int POP_MAX  = 1,
  parameter int AW       = $clog2(DEPTH),
  parameter int CNT_W    = AW + 1,
  parameter int PN_W     = $clog2(PUSH_MAX + 1),
  parameter int QN_W     = $clog2(POP_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic [PN_W-1:0]       push_n,
  input  logic [PUSH_MAX*8-1:0] push_bytes,
  input  logic [QN_W-1:0]       pop_n,
  output logic [POP_MAX*8-1:0]  peek,
  output logic [CNT_W-1:0]      level
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  // storage: byte k of the push vector goes k places after the write pointer
  always_ff @(posedge clk) begin
    if (!flush) begin
      for (int k = 0; k < PUSH_MAX; k++) begin
        if (PN_W'(k) < push_n) mem[wr_ptr + AW'(k)] <= push_bytes[8*k +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      rd_ptr <= wr_ptr;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push_n);
      rd_ptr <= rd_ptr + AW'(pop_n);
      level  <= level + CNT_W'(push_n) - CNT_W'(pop_n);
    end
  end

  for (genvar g = 0; g < POP_MAX; g++) begin : g_peek
    assign peek[8*g +: 8] = mem[rd_ptr + AW'(g)];
  end
endmodule

// File: rtl/bm_xfer_ctrl.sv
module bm_xfer_ctrl
  import bm_pkg::*;
#(
  parameter int NBLK_W = 16,
  parameter int BLEN_W = 12,
  parameter int LEFT_W = NBLK_W + BLEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_dir,
  input  logic [NBLK_W-1:0] start_blocks,
  input  logic [BLEN_W-1:0] start_blklen,
  input  logic              abort,
  input  logic              moved,
  output logic              active,
  output xfer_dir_e         dir_q,
  output logic [LEFT_W-1:0] bytes_left,
  output logic              data_done,
  output logic              prog_done
);
  logic [LEFT_W-1:0] total;
  assign total = LEFT_W'(start_blocks) * LEFT_W'(start_blklen);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      dir_q      <= DIR_TO_CPU;
      bytes_left <= '0;
      data_done  <= 1'b0;
      prog_done  <= 1'b0;
    end else if (abort) begin
      active <= 1'b0;
    end else if (start) begin
      bytes_left <= total;
      dir_q      <= xfer_dir_e'(start_dir);
      active     <= (total != '0);
      data_done  <= (total == '0);
      prog_done  <= (total == '0) && start_dir;
    end else if (moved && active) begin
      bytes_left <= bytes_left - LEFT_W'(1);
      if (bytes_left == LEFT_W'(1)) begin
        active    <= 1'b0;
        data_done <= 1'b1;
        prog_done <= (dir_q == DIR_TO_CARD);
      end
    end
  end
endmodule

// File: rtl/bm_svc_req.sv
module bm_svc_req (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rx_push,
  input  logic rx_pop_strobe,
  input  logic tx_push_strobe,
  input  logic tx_starved,
  output logic rx_req,
  output logic tx_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_req <= 1'b0;
      tx_req <= 1'b0;
    end else if (start) begin
      rx_req <= 1'b0;
      tx_req <= 1'b0;
    end else begin
      if (rx_push)            rx_req <= 1'b1;
      else if (rx_pop_strobe) rx_req <= 1'b0;
      if (tx_push_strobe)     tx_req <= 1'b0;
      else if (tx_starved)    tx_req <= 1'b1;
    end
  end
endmodule

// File: rtl/card_byte_mover.sv
module card_byte_mover
  import bm_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int NBLK_W = 16,
  parameter int BLEN_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       start_dir,
  input  logic [NBLK_W-1:0]          start_blocks,
  input  logic [BLEN_W-1:0]          start_blklen,
  input  logic                       abort,
  input  logic                       tx_release,
  input  logic                       cpu_rd,
  input  logic                       cpu_wr,
  input  logic [1:0]                 acc_size,
  input  logic [31:0]                cpu_wdata,
  output logic [31:0]                cpu_rdata,
  input  logic                       card_rx_valid,
  input  logic [7:0]                 card_rx_data,
  output logic                       card_rx_ready,
  output logic                       card_tx_valid,
  output logic [7:0]                 card_tx_data,
  input  logic                       card_tx_ready,
  output logic                       rx_req,
  output logic                       tx_req,
  output logic                       data_done,
  output logic                       prog_done,
  output logic                       active,
  output logic [NBLK_W+BLEN_W-1:0]   bytes_left,
  output logic [$clog2(DEPTH):0]     rx_level,
  output logic [$clog2(DEPTH):0]     tx_level
);
  localparam int AW     = $clog2(DEPTH);
  localparam int CNT_W  = AW + 1;
  localparam int LEFT_W = NBLK_W + BLEN_W;
  localparam int MN_W   = $clog2(CPU_BYTES + 1);

  xfer_dir_e         dir_q;
  logic [2:0]        nbytes;
  logic [CNT_W-1:0]  rx_take_w, tx_space, tx_put_w;
  logic [MN_W-1:0]   rx_pop_n, tx_push_n;
  logic [CPU_BYTES*8-1:0] rx_peek, tx_push_bytes;
  logic [7:0]        tx_peek;
  logic              rx_push, tx_pop, moved, tx_starved;

  assign nbytes = acc_bytes(acc_size);

  // card-side handshakes
  assign card_rx_ready = active && (dir_q == DIR_TO_CPU) && (bytes_left != '0)
                         && (rx_level < CNT_W'(DEPTH)) && !abort;
  assign card_tx_valid = active && (dir_q == DIR_TO_CARD) && (tx_level != '0)
                         && !abort && !tx_release;
  assign card_tx_data  = tx_peek;
  assign rx_push       = card_rx_valid && card_rx_ready;
  assign tx_pop        = card_tx_valid && card_tx_ready;
  assign moved         = rx_push || tx_pop;

  // receive side: pop up to nbytes, whatever is present
  assign rx_take_w = (CNT_W'(nbytes) < rx_level) ? CNT_W'(nbytes) : rx_level;
  assign rx_pop_n  = cpu_rd ? MN_W'(rx_take_w) : '0;

  always_comb begin
    cpu_rdata = '0;
    for (int l = 0; l < CPU_BYTES; l++) begin
      int idx;
      idx = int'(nbytes) - 1 - l;
      if (cpu_rd && idx >= 0 && idx < int'(rx_take_w))
        cpu_rdata[8*l +: 8] = rx_peek[8*idx +: 8];
    end
  end

  // transmit side: accept up to the free space, drop the rest
  assign tx_space  = CNT_W'(DEPTH) - tx_level;
  assign tx_put_w  = (CNT_W'(nbytes) < tx_space) ? CNT_W'(nbytes) : tx_space;
  assign tx_push_n = (cpu_wr && !tx_release) ? MN_W'(tx_put_w) : '0;

  always_comb begin
    tx_push_bytes = '0;
    for (int k = 0; k < CPU_BYTES; k++) begin
      int idx;
      idx = int'(nbytes) - 1 - k;
      if (idx >= 0) tx_push_bytes[8*k +: 8] = cpu_wdata[8*idx +: 8];
    end
  end

  assign tx_starved = active && (dir_q == DIR_TO_CARD) && (bytes_left != '0)
                      && (tx_level == '0);

  bm_byte_ring #(.DEPTH(DEPTH), .PUSH_MAX(1), .POP_MAX(CPU_BYTES)) u_rx_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (start),
    .push_n     (rx_push),
    .push_bytes (card_rx_data),
    .pop_n      (rx_pop_n),
    .peek       (rx_peek),
    .level      (rx_level)
  );

  bm_byte_ring #(.DEPTH(DEPTH), .PUSH_MAX(CPU_BYTES), .POP_MAX(1)) u_tx_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (start || tx_release),
    .push_n     (tx_push_n),
    .push_bytes (tx_push_bytes),
    .pop_n      (tx_pop),
    .peek       (tx_peek),
    .level      (tx_level)
  );

  bm_xfer_ctrl #(.NBLK_W(NBLK_W), .BLEN_W(BLEN_W), .LEFT_W(LEFT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .start_dir    (start_dir),
    .start_blocks (start_blocks),
    .start_blklen (start_blklen),
    .abort        (abort),
    .moved        (moved),
    .active       (active),
    .dir_q        (dir_q),
    .bytes_left   (bytes_left),
    .data_done    (data_done),
    .prog_done    (prog_done)
  );

  bm_svc_req u_req (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .rx_push        (rx_push),
    .rx_pop_strobe  (cpu_rd),
    .tx_push_strobe (cpu_wr),
    .tx_starved     (tx_starved),
    .rx_req         (rx_req),
    .tx_req         (tx_req)
  );
endmodule

// File: rtl/bm_checker.sv
module bm_checker #(
  parameter int DEPTH  = 32,
  parameter int LEFT_W = 28,
  parameter int CNT_W  = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              abort,
  input logic              active,
  input logic              data_done,
  input logic              prog_done,
  input logic [LEFT_W-1:0] bytes_left,
  input logic [CNT_W-1:0]  rx_level,
  input logic [CNT_W-1:0]  tx_level,
  input logic              card_rx_valid,
  input logic              card_rx_ready,
  input logic              card_tx_valid,
  input logic              card_tx_ready
);
  logic moved;
  assign moved = (card_rx_valid && card_rx_ready) || (card_tx_valid && card_tx_ready);

  AST_RX_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= CNT_W'(DEPTH)); // R2
  AST_TX_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= CNT_W'(DEPTH)); // R5
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_rx_ready && card_tx_valid)); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (moved && !start && !abort) |=> bytes_left == $past(bytes_left) - LEFT_W'(1)); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    data_done |-> !active); // R7
  AST_PROG_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |-> data_done); // R7
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !card_rx_ready && !card_tx_valid); // R9
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !active && $stable(bytes_left)); // R9
endmodule

bind card_byte_mover bm_checker #(.DEPTH(DEPTH), .LEFT_W(NBLK_W + BLEN_W)) u_bm_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .abort         (abort),
  .active        (active),
  .data_done     (data_done),
  .prog_done     (prog_done),
  .bytes_left    (bytes_left),
  .rx_level      (rx_level),
  .tx_level      (tx_level),
  .card_rx_valid (card_rx_valid),
  .card_rx_ready (card_rx_ready),
  .card_tx_valid (card_tx_valid),
  .card_tx_ready (card_tx_ready)
);

// File: tb/tb_card_byte_mover.sv
`timescale 1ns/1ps
module tb_card_byte_mover;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, start_dir, abort, tx_release, cpu_rd, cpu_wr;
  logic [15:0] start_blocks;
  logic [11:0] start_blklen;
  logic [1:0]  acc_size;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        card_rx_valid, card_rx_ready, card_tx_valid, card_tx_ready;
  logic [7:0]  card_rx_data, card_tx_data;
  logic        rx_req, tx_req, data_done, prog_done, active;
  logic [27:0] bytes_left;
  logic [5:0]  rx_level, tx_level;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  card_byte_mover dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 37 + seed * 11 + 5) & 255);
  endfunction

  function automatic int size_bytes(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_read(input int n, input int take, input int base, input int seed);
    logic [31:0] r = '0;
    for (int l = 0; l < 4; l++) begin
      int idx = n - 1 - l;
      if (idx >= 0 && idx < take) r[8*l +: 8] = pat(base + idx, seed);
    end
    return r;
  endfunction

  function automatic logic [31:0] make_wdata(input int n, input int base, input int seed);
    logic [31:0] r = '0;
    for (int k = 0; k < n; k++) r[8*(n-1-k) +: 8] = pat(base + k, seed);
    return r;
  endfunction

  task automatic idle();
    start = 0; abort = 0; tx_release = 0; cpu_rd = 0; cpu_wr = 0;
    acc_size = 0; cpu_wdata = 0; card_rx_valid = 0; card_rx_data = 0; card_tx_ready = 0;
  endtask

  task automatic do_start(input bit dir, input int nb, input int bl);
    int prod = nb * bl;
    @(negedge clk); idle();
    start = 1; start_dir = dir; start_blocks = 16'(nb); start_blklen = 12'(bl);
    @(negedge clk); idle(); #1;
    chk(active == (prod != 0), "R1", "active after start", active, prod != 0);
    chk(int'(bytes_left) == prod, "R1", "bytes_left loaded", bytes_left, prod);
    chk(data_done == (prod == 0), "R1", "data_done after start", data_done, prod == 0);
    chk(prog_done == (prod == 0 && dir), "R1", "prog_done after start", prog_done, prod == 0 && dir);
    chk(rx_level == 0 && tx_level == 0, "R1", "fifos emptied", {rx_level, tx_level}, 0);
  endtask

  task automatic run_read(input int nb, input int bl, input int seed, input int rdpct);
    int total = nb * bl, sent = 0, got = 0, guard = 0;
    bit exp_rx = 0;
    do_start(0, nb, bl);
    while ((sent < total || got < total) && guard < 20000) begin
      int lvl, n, take;
      bit push;
      guard++;
      @(negedge clk); idle();
      card_rx_valid = (sent < total) && ($urandom % 100 < 70);
      card_rx_data  = pat(sent, seed);
      cpu_rd   = ($urandom % 100) < rdpct;
      acc_size = 2'($urandom % 4);
      #1;
      lvl = int'(rx_level);
      chk(lvl == sent - got, "R2", "rx_level", lvl, sent - got);
      chk(card_rx_ready == (sent < total && lvl < 32), "R2", "card_rx_ready", card_rx_ready,
          sent < total && lvl < 32);
      chk(rx_req == exp_rx, "R2", "rx_req", rx_req, exp_rx);
      push = card_rx_valid && card_rx_ready;
      if (cpu_rd) begin
        n = size_bytes(int'(acc_size));
        take = (n < lvl) ? n : lvl;
        chk(cpu_rdata == exp_read(n, take, got, seed), "R3", "cpu_rdata lanes (R10 order)",
            cpu_rdata, exp_read(n, take, got, seed));
        got += take;
      end
      if (push) begin sent++; exp_rx = 1; end
      else if (cpu_rd) exp_rx = 0;
    end
    @(negedge clk); idle(); #1;
    chk(!active && data_done, "R7", "read completion", {active, data_done}, 1);
    chk(!prog_done, "R7", "no prog_done on read", prog_done, 0);
    chk(bytes_left == 0, "R7", "bytes_left at end", bytes_left, 0);
  endtask

  task automatic run_write(input int nb, input int bl, input int seed, input int wrpct, input int rdypct);
    int total = nb * bl, pushed = 0, popped = 0, guard = 0;
    bit exp_tx;
    do_start(1, nb, bl);
    exp_tx = (total != 0);
    while (popped < total && guard < 20000) begin
      int lvl, n, put;
      bit vexp;
      guard++;
      @(negedge clk); idle();
      cpu_wr = (pushed < total) && ($urandom % 100 < wrpct);
      acc_size = 2'($urandom % 4);
      n = size_bytes(int'(acc_size));
      cpu_wdata = make_wdata(n, pushed, seed);
      card_tx_ready = ($urandom % 100) < rdypct;
      #1;
      lvl = int'(tx_level);
      chk(lvl == pushed - popped, "R5", "tx_level", lvl, pushed - popped);
      vexp = (popped < total) && lvl > 0;
      chk(card_tx_valid == vexp, "R4", "card_tx_valid", card_tx_valid, vexp);
      chk(tx_req == exp_tx, "R6", "tx_req", tx_req, exp_tx);
      if (card_tx_valid && card_tx_ready) begin
        chk(card_tx_data == pat(popped, seed), "R10", "card_tx_data order", card_tx_data, pat(popped, seed));
        popped++;
      end
      if (cpu_wr) exp_tx = 0;
      else if (lvl == 0 && (total - (popped - ((card_tx_valid && card_tx_ready) ? 1 : 0))) > 0) exp_tx = 1;
      if (cpu_wr) begin
        put = (n < 32 - lvl) ? n : 32 - lvl;
        pushed += put;
      end
    end
    @(negedge clk); idle(); #1;
    chk(!active && data_done && prog_done, "R7", "write completion flags", {active, data_done, prog_done}, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    rst_n = 0; start_dir = 0; start_blocks = 0; start_blklen = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk(!active && !data_done && !prog_done, "R1", "reset flags", {active, data_done, prog_done}, 0);
    chk(rx_level == 0 && tx_level == 0, "R1", "reset levels", {rx_level, tx_level}, 0);
    chk(!rx_req && !tx_req && !card_rx_ready && !card_tx_valid, "R1", "reset handshakes",
        {rx_req, tx_req, card_rx_ready, card_tx_valid}, 0);

    // zero-length transfers
    do_start(0, 0, 5);
    do_start(1, 3, 0);

    // transmit request, lane order, overflow and release
    do_start(1, 2, 32);
    @(negedge clk); #1;
    chk(tx_req, "R6", "tx_req after empty start", tx_req, 1);
    @(negedge clk); idle(); cpu_wr = 1; acc_size = 2; cpu_wdata = 32'hA1B2C3D4;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); idle(); cpu_wr = 1; acc_size = 2; cpu_wdata = 32'h01020304 + i;
      #1;
      if (i == 0) begin
        chk(card_tx_valid && card_tx_data == 8'hA1, "R5", "first byte from top lane", card_tx_data, 8'hA1);
        chk(!tx_req, "R5", "tx_req cleared by write", tx_req, 0);
      end
    end
    @(negedge clk); idle(); #1;
    chk(tx_level == 32, "R5", "overflow bytes dropped", tx_level, 32);
    tx_release = 1; #1;
    chk(!card_tx_valid, "R8", "no offer during release", card_tx_valid, 0);
    @(negedge clk); idle(); #1;
    chk(tx_level == 0, "R8", "release empties fifo", tx_level, 0);
    @(negedge clk); #1;
    chk(tx_req, "R6", "tx_req after release", tx_req, 1);
    abort = 1;
    @(negedge clk); idle(); #1;
    chk(!active && !data_done && bytes_left == 64, "R9", "abort on write", {active, data_done, bytes_left}, 64);

    // abort during read, then partial multi-byte read
    do_start(0, 1, 16);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); idle(); card_rx_valid = 1; card_rx_data = 8'h50 + 8'(i);
    end
    @(negedge clk); idle(); card_rx_valid = 1; card_rx_data = 8'h77; abort = 1; #1;
    chk(!card_rx_ready, "R9", "no ready during abort", card_rx_ready, 0);
    @(negedge clk); idle(); #1;
    chk(!active && bytes_left == 13 && rx_level == 3, "R9", "held count after abort",
        {active, bytes_left, rx_level}, {1'b0, 28'd13, 6'd3});
    cpu_rd = 1; acc_size = 2; #1;
    chk(cpu_rdata == 32'h50515200, "R3", "partial 4-byte read", cpu_rdata, 32'h50515200);
    @(negedge clk); idle(); #1;
    chk(!rx_req && rx_level == 0, "R3", "rx_req cleared by read", {rx_req, rx_level}, 0);

    // random traffic, including full-fifo back-pressure and wrap-around
    run_read(3, 20, 1, 40);
    run_read(2, 45, 2, 8);
    run_write(3, 20, 3, 40, 60);
    run_write(2, 40, 4, 90, 10);
    run_read(1, 7, 5, 90);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule